// File: doc/BRIEF.md
# Remote Page Interleaver

This block sits in front of an accelerator's memory ports and turns a device-side physical address into a target and a target-relative address. The unified address space of one accelerator starts with its own memory. Above that sits its share of two neighbouring memory nodes, the left share first and then the right share. Software sets the local size and the per-node remote share, both counted in pages. The block keeps every mapping inside those limits.

There are two placement modes. In linear mode, the first remote window maps to the left node and the next one maps to the right node. In striped mode, consecutive remote pages alternate between the two nodes, so one remote allocation is split evenly and both link sets carry traffic at the same time. An address above the configured space raises an error flag and selects no target.

Translation is combinational, followed by a single output register. The block takes one request per cycle, with one cycle of latency.

Top module: `remote_page_interleaver`

## Requirements
- R1: While reset is held and in the first cycle after it, rsp_valid is 0, rsp_target is 0 (none), rsp_err is 0 and rsp_addr is 0.
- R2: The outputs in a cycle reflect the request of the previous cycle. rsp_valid equals the previous req_valid. An idle cycle produces target 0, err 0 and addr 0.
- R3: Let page = req_addr >> PAGE_W. If page < cfg_local_pages, rsp_target is 1 (local) and rsp_addr equals req_addr.
- R4: With mode_stripe = 0, let rp = page - cfg_local_pages. If rp < cfg_share_pages, the target is 2 (left) with node page rp. If cfg_share_pages <= rp < 2*cfg_share_pages, the target is 3 (right) with node page rp - cfg_share_pages.
- R5: With mode_stripe = 1 and rp < 2*cfg_share_pages, an even rp selects 2 (left) and an odd rp selects 3 (right), using the default STRIPE_LEFT_EVEN = 1. The node page is rp >> 1.
- R6: For every non-error request, the low PAGE_W bits of rsp_addr equal those of req_addr.
- R7: If page >= cfg_local_pages + 2*cfg_share_pages, rsp_err is 1, rsp_target is 0 and rsp_addr is 0. This includes the case of a zero share.
- R8: Whenever the target is left or right, the node page in rsp_addr[ADDR_W-1:PAGE_W] is less than cfg_share_pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Device-side physical address |
| mode_stripe | input | 1 | 1 = alternate remote pages between nodes, 0 = linear windows |
| cfg_local_pages | input | ADDR_W-PAGE_W | Local memory size in pages |
| cfg_share_pages | input | ADDR_W-PAGE_W | Remote share per neighbour node in pages |
| rsp_valid | output | 1 | Translation result present |
| rsp_target | output | 2 | 0 none, 1 local, 2 left, 3 right |
| rsp_addr | output | ADDR_W | Address relative to the selected target |
| rsp_err | output | 1 | Address beyond the configured space |

## Verification
The hardest cases to reach are at the region edges. These are the last local page, the split between the left and right windows in linear mode, and the last remote page, together with a zero share, where the remote space vanishes. The stimulus walks every page across small configured sizes in both modes, so that each edge is crossed in both directions. It then repeats random requests with small sizes and page numbers, so that the edges recur under changing configuration and mode.

// File: rtl/pgil_pkg.sv
package pgil_pkg;
   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_LOCAL = 2'd1,
      TGT_LEFT  = 2'd2,
      TGT_RIGHT = 2'd3
   } tgt_e;
endpackage

// File: rtl/pgil_region_decode.sv
module pgil_region_decode #(
   parameter int PN_W = 20
) (
   input  logic [PN_W-1:0] page,
   input  logic [PN_W-1:0] local_pages,
   input  logic [PN_W-1:0] share_pages,
   output logic            is_local,
   output logic            is_remote,
   output logic            is_oob,
   output logic [PN_W-1:0] rem_page
);
   localparam int EXT_W = PN_W + 2;

   logic [EXT_W-1:0] page_x;
   logic [EXT_W-1:0] lim_local;
   logic [EXT_W-1:0] lim_all;

   always_comb begin
      page_x    = {2'b00, page};
      lim_local = {2'b00, local_pages};
      lim_all   = lim_local + ({2'b00, share_pages} << 1);
      is_local  = page_x < lim_local;
      is_oob    = page_x >= lim_all;
      is_remote = !is_local && !is_oob;
      rem_page  = page - local_pages;
   end

   always_comb begin
      assert_one_region_R7: assert ($countones({is_local, is_remote, is_oob}) == 1)
         else $error("region decode not exclusive");
   end
endmodule

// File: rtl/pgil_remote_map.sv
module pgil_remote_map #(
   parameter int PN_W             = 20,
   parameter bit STRIPE_LEFT_EVEN = 1'b1
) (
   input  logic            mode_stripe,
   input  logic [PN_W-1:0] rem_page,
   input  logic [PN_W-1:0] share_pages,
   output logic            sel_right,
   output logic [PN_W-1:0] node_page
);
   logic            lin_right;
   logic [PN_W-1:0] lin_page;
   logic            str_right;
   logic [PN_W-1:0] str_page;

   always_comb begin
      lin_right = rem_page >= share_pages;
      lin_page  = lin_right ? (rem_page - share_pages) : rem_page;
      str_page  = {1'b0, rem_page[PN_W-1:1]};
   end

   generate
      if (STRIPE_LEFT_EVEN) begin : g_even_left
         assign str_right = rem_page[0];
      end else begin : g_even_right
         assign str_right = ~rem_page[0];
      end
   endgenerate

   always_comb begin
      sel_right = mode_stripe ? str_right : lin_right;
      node_page = mode_stripe ? str_page  : lin_page;
   end
endmodule

// File: rtl/pgil_out_reg.sv
module pgil_out_reg #(
   parameter int ADDR_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  pgil_pkg::tgt_e      in_tgt,
   input  logic [ADDR_W-1:0]   in_addr,
   input  logic                in_err,
   output logic                out_valid,
   output pgil_pkg::tgt_e      out_tgt,
   output logic [ADDR_W-1:0]   out_addr,
   output logic                out_err
);
   import pgil_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_tgt   <= TGT_NONE;
         out_addr  <= '0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_tgt   <= in_valid ? in_tgt : TGT_NONE;
         out_addr  <= in_valid ? in_addr : '0;
         out_err   <= in_valid && in_err;
      end
   end

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && out_tgt == TGT_NONE && !out_err));
endmodule

// File: rtl/remote_page_interleaver.sv
module remote_page_interleaver #(
   parameter int ADDR_W           = 32,
   parameter int PAGE_W           = 12,
   parameter bit STRIPE_LEFT_EVEN = 1'b1,
   localparam int PN_W            = ADDR_W - PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              mode_stripe,
   input  logic [PN_W-1:0]   cfg_local_pages,
   input  logic [PN_W-1:0]   cfg_share_pages,
   output logic              rsp_valid,
   output logic [1:0]        rsp_target,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_err
);
   import pgil_pkg::*;

   generate
      if (PAGE_W < 1 || PAGE_W >= ADDR_W - 1) begin : g_bad_page
         $error("PAGE_W must leave at least two page-number bits");
      end
   endgenerate

   logic [PN_W-1:0]   page;
   logic [PAGE_W-1:0] offset;
   logic              is_local, is_remote, is_oob;
   logic [PN_W-1:0]   rem_page;
   logic              sel_right;
   logic [PN_W-1:0]   node_page;
   tgt_e              nxt_tgt;
   logic [ADDR_W-1:0] nxt_addr;
   tgt_e              q_tgt;

   assign page   = req_addr[ADDR_W-1:PAGE_W];
   assign offset = req_addr[PAGE_W-1:0];

   pgil_region_decode #(.PN_W(PN_W)) u_region (
      .page        (page),
      .local_pages (cfg_local_pages),
      .share_pages (cfg_share_pages),
      .is_local    (is_local),
      .is_remote   (is_remote),
      .is_oob      (is_oob),
      .rem_page    (rem_page)
   );

   pgil_remote_map #(.PN_W(PN_W), .STRIPE_LEFT_EVEN(STRIPE_LEFT_EVEN)) u_map (
      .mode_stripe (mode_stripe),
      .rem_page    (rem_page),
      .share_pages (cfg_share_pages),
      .sel_right   (sel_right),
      .node_page   (node_page)
   );

   always_comb begin
      nxt_tgt  = TGT_NONE;
      nxt_addr = '0;
      if (is_local) begin
         nxt_tgt  = TGT_LOCAL;
         nxt_addr = req_addr;
      end else if (is_remote) begin
         nxt_tgt  = sel_right ? TGT_RIGHT : TGT_LEFT;
         nxt_addr = {node_page, offset};
      end
   end

   pgil_out_reg #(.ADDR_W(ADDR_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_tgt    (nxt_tgt),
      .in_addr   (nxt_addr),
      .in_err    (is_oob),
      .out_valid (rsp_valid),
      .out_tgt   (q_tgt),
      .out_addr  (rsp_addr),
      .out_err   (rsp_err)
   );

   assign rsp_target = q_tgt;

   assert_err_no_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_target == 2'd0 && rsp_addr == '0));
   assert_capacity_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_target[1]) |-> (rsp_addr[ADDR_W-1:PAGE_W] < $past(cfg_share_pages)));
   assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err) |-> (rsp_addr[PAGE_W-1:0] == $past(req_addr[PAGE_W-1:0])));
   assert_local_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_target == 2'd1) |-> (rsp_addr == $past(req_addr)));
endmodule

// File: tb/tb_remote_page_interleaver.sv
module tb_remote_page_interleaver;
   localparam int ADDR_W = 32;
   localparam int PAGE_W = 12;
   localparam int PN_W   = ADDR_W - PAGE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              mode_stripe = 1'b0;
   logic [PN_W-1:0]   cfg_local_pages = '0;
   logic [PN_W-1:0]   cfg_share_pages = '0;
   logic              rsp_valid;
   logic [1:0]        rsp_target;
   logic [ADDR_W-1:0] rsp_addr;
   logic              rsp_err;

   int total = 0;
   int bad = 0;
   bit done = 0;

   int    e_valid = 0, e_tgt = 0, e_err = 0, e_share = 0;
   longint e_addr = 0;
   string e_tag = "R1";

   always #5 clk = ~clk;

   remote_page_interleaver #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .mode_stripe(mode_stripe), .cfg_local_pages(cfg_local_pages),
      .cfg_share_pages(cfg_share_pages), .rsp_valid(rsp_valid),
      .rsp_target(rsp_target), .rsp_addr(rsp_addr), .rsp_err(rsp_err)
   );

   task automatic chk(string tag, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare();
      chk(e_tag, {rsp_valid, rsp_err, rsp_target}, {e_valid[0], e_err[0], e_tgt[1:0]});
      chk(e_tag, rsp_addr, e_addr);
      if (e_valid != 0 && e_err == 0)
         chk("R6", rsp_addr % 4096, req_addr_prev % 4096);
      if (e_tgt >= 2)
         chk("R8", (rsp_addr >> PAGE_W) < e_share, 1);
   endtask

   longint req_addr_prev = 0;

   task automatic model(int v, longint a, int m, int lp, int s);
      longint pg, off, rp, np;
      pg = a >> PAGE_W;
      off = a % 4096;
      e_share = s;
      req_addr_prev = a;
      e_valid = v; e_tgt = 0; e_err = 0; e_addr = 0;
      if (v == 0) e_tag = "R2";
      else if (pg < lp) begin e_tgt = 1; e_addr = a; e_tag = "R3"; end
      else if (pg < lp + 2 * s) begin
         rp = pg - lp;
         if (m != 0) begin
            e_tgt = (rp % 2 == 1) ? 3 : 2; np = rp / 2; e_tag = "R5";
         end else if (rp < s) begin
            e_tgt = 2; np = rp; e_tag = "R4";
         end else begin
            e_tgt = 3; np = rp - s; e_tag = "R4";
         end
         e_addr = np * 4096 + off;
      end else begin
         e_err = 1; e_tag = "R7";
      end
   endtask

   task automatic step(int v, longint a, int m, int lp, int s);
      @(negedge clk);
      compare();
      req_valid = v[0];
      req_addr = a[ADDR_W-1:0];
      mode_stripe = m[0];
      cfg_local_pages = lp[PN_W-1:0];
      cfg_share_pages = s[PN_W-1:0];
      model(v, a, m, lp, s);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         chk("R1", {rsp_valid, rsp_err, rsp_target}, 0);
         chk("R1", rsp_addr, 0);
      end
      rst_n = 1'b1;
      e_tag = "R1";
      // directed walk, linear then striped, lp=4 s=3
      for (int m = 0; m < 2; m++)
         for (int p = 0; p < 12; p++)
            step(1, longint'(p) * 4096 + p * 37 + 5, m, 4, 3);
      step(0, 0, 0, 4, 3);
      step(0, 32'hFFFF_FFFF, 1, 4, 3);
      // zero share: everything above local out of range (R7)
      for (int p = 0; p < 4; p++) step(1, longint'(p) * 4096 + 4095, 1, 2, 0);
      // zero local: remote starts at page 0
      for (int m = 0; m < 2; m++)
         for (int p = 0; p < 6; p++) step(1, longint'(p) * 4096 + 1, m, 0, 2);
      // top of address space
      step(1, 32'hFFFF_F123, 0, 5, 5);
      // random
      for (int i = 0; i < 400; i++) begin
         int lp, s, p, m, v;
         lp = $urandom_range(0, 7);
         s  = $urandom_range(0, 7);
         p  = $urandom_range(0, 24);
         m  = $urandom_range(0, 1);
         v  = ($urandom_range(0, 7) != 0) ? 1 : 0;
         step(v, longint'(p) * 4096 + $urandom_range(0, 4095), m, lp, s);
      end
      step(0, 0, 0, 0, 0);
      @(negedge clk);
      compare();
      finish_run();
   end
endmodule